// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Selective Invalidation

This block holds a small, fully associative set of cached page translations for 4 KiB pages. Each line carries a 7-bit address-space tag, a 20-bit virtual page number (VA[31:12]), a 20-bit physical frame number and three permission bits. A lookup presents a tag and a page number. A hit answers on the next cycle with the frame and the permissions. A miss in the idle state raises one refill request toward an external table walker. The walker's answer installs a new line and is also passed back as the response to the lookup that missed.

Software-style invalidation arrives as a single packed 32-bit command word. The word can drop every line, the lines of one 4 MiB section or the lines of one 16 KiB group, and it can optionally restrict the drop to one address space. Two configuration inputs set the behaviour. A 6-bit count limits how many lines are in use. An enable lets hit lookups proceed while a refill is still outstanding.

Top module: `asid_tlb`

## Requirements
- R1: A lookup accepted at a clock edge that matches a valid active line on both the address-space tag and the page number gives, after that edge, `rsp_valid`=1, `rsp_hit`=1, `rsp_retry`=0, and the stored frame and permission code. The permission code is the 3-bit value {read, write, nonsecure}. A different tag with the same page number does not hit.
- R2: A lookup that misses while no refill is outstanding produces no response. After that edge, `miss_valid`=1 with the lookup's tag and page number. `miss_valid` and these values stay unchanged until an edge where `miss_ready`=1.
- R3: Once the request has been taken, `fill_ready`=1. A `fill_valid` at an edge installs the line and gives, after that edge, `rsp_valid`=1, `rsp_hit`=0, `rsp_retry`=0, and the fill's frame and permission code. A later lookup of the same page hits.
- R4: The invalidation mode sits in command bits 1:0. Value 0 drops all addresses. Value 2 drops lines whose VA[31:22] equals bits 19:10. Value 3 drops lines whose VA[31:14] equals bits 19:2. Value 1 drops nothing. Lines leave the cache after the edge at which `flush_valid`=1.
- R5: When command bit 31 is 1, only lines whose tag equals bits 30:24 are dropped. When bit 31 is 0, the tag plays no part.
- R6: `cfg_active_lines` sets how many of the lowest-numbered lines are in use, capped at the line count. Lines at or above it never hit and are never filled. With a count of 0 a refill still answers, but nothing is installed.
- R7: A fill goes to the lowest-numbered invalid active line. If there is none, it goes to a round-robin pointer. The pointer advances by one on every installed fill and wraps at the active count.
- R8: With `cfg_hum_en`=1 lookups are accepted during a refill. A hit is answered as in R1. A miss is answered with `rsp_valid`=1, `rsp_retry`=1, and no new request. With `cfg_hum_en`=0, `lk_ready`=0 while a refill is outstanding.
- R9: A fill arriving at the same edge as an invalidation that covers the pending tag and page is not installed. It is answered with `rsp_valid`=1 and `rsp_retry`=1. A fill with a non-covering invalidation is installed normally.
- R10: After reset all lines are invalid, `lk_ready`=1, and `rsp_valid`, `miss_valid` and `fill_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_active_lines | input | 6 | Number of lines in use |
| cfg_hum_en | input | 1 | Allow lookups during an outstanding refill |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_asid | input | 7 | Lookup address-space tag |
| lk_vpn | input | 20 | Lookup page number VA[31:12] |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Response came from a cached line |
| rsp_retry | output | 1 | Lookup must be reissued |
| rsp_pfn | output | 20 | Response frame number |
| rsp_perm | output | 3 | Response {read, write, nonsecure} |
| miss_valid | output | 1 | Refill request |
| miss_ready | input | 1 | Walker takes the request |
| miss_asid | output | 7 | Tag of the request |
| miss_vpn | output | 20 | Page number of the request |
| fill_valid | input | 1 | Walker answer |
| fill_ready | output | 1 | Answer can be taken |
| fill_pfn | input | 20 | Answer frame number |
| fill_perm | input | 3 | Answer {read, write, nonsecure} |
| flush_valid | input | 1 | Invalidation command strobe |
| flush_word | input | 32 | Packed invalidation command |

## Verification
Hit responses and fill responses are registered, so each appears one edge after the lookup or fill that causes it. Refill requests also appear one edge after the missing lookup. An invalidation removes lines one edge after it is presented. The bench drives every input on a falling edge and reads the outputs at the next falling edge, half a cycle after the edge that produces them. To reach the replacement order and the invalidation effects without looking inside the block, the bench probes lines with lookups. Any probe that misses is completed with a refill, so the expected cache contents stay tracked from the requirements alone.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  localparam int ASID_W = 7;
  localparam int VPN_W  = 20;
  localparam int PFN_W  = 20;
  localparam int PERM_W = 3;

  typedef enum logic [1:0] {
    FM_ALL   = 2'd0,
    FM_NONE  = 2'd1,
    FM_SECT  = 2'd2,
    FM_GROUP = 2'd3
  } fmode_e;

  typedef struct packed {
    logic              asid_chk;
    logic [ASID_W-1:0] asid;
    fmode_e            mode;
    logic [VPN_W-1:0]  vpn_key;
  } flush_cmd_t;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [PERM_W-1:0] perm;
  } entry_t;

  function automatic logic flush_covers(flush_cmd_t c, logic [ASID_W-1:0] asid,
                                        logic [VPN_W-1:0] vpn);
    logic tag_ok;
    logic va_ok;
    tag_ok = !c.asid_chk || (c.asid == asid);
    case (c.mode)
      FM_ALL:   va_ok = 1'b1;
      FM_SECT:  va_ok = (c.vpn_key[VPN_W-1:10] == vpn[VPN_W-1:10]);
      FM_GROUP: va_ok = (c.vpn_key[VPN_W-1:2] == vpn[VPN_W-1:2]);
      default:  va_ok = 1'b0;
    endcase
    return tag_ok && va_ok;
  endfunction

endpackage

// File: rtl/tlb_flush_dec.sv
module tlb_flush_dec
  import asid_tlb_pkg::*;
(
  input  logic        flush_valid,
  input  logic [31:0] flush_word,
  output logic        flush_go,
  output flush_cmd_t  flush_cmd
);

  // bits 23:20 carry nothing for any mode
  logic unused_hi;
  assign unused_hi = ^flush_word[23:20];

  assign flush_go           = flush_valid;
  assign flush_cmd.asid_chk = flush_word[31];
  assign flush_cmd.asid     = flush_word[30:24];
  assign flush_cmd.mode     = fmode_e'(flush_word[1:0]);
  assign flush_cmd.vpn_key  = {flush_word[19:2], 2'b00};

endmodule

// File: rtl/tlb_tag_array.sv
module tlb_tag_array
  import asid_tlb_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  active_cnt,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              flush_go,
  input  flush_cmd_t        flush_cmd,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  entry_t            wr_entry,
  output logic              hit,
  output entry_t            hit_ent,
  output logic [LINES-1:0]  vld_vec
);

  logic [LINES-1:0] match;
  entry_t           ent_w [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic   v_q;
    entry_t e_q;
    logic   in_use;
    logic   drop;
    logic   take;

    assign in_use = (CNT_W'(i) < active_cnt);
    assign take   = wr_en && (wr_idx == IDX_W'(i));
    assign drop   = flush_go && flush_covers(flush_cmd, e_q.asid, e_q.vpn);
    assign match[i] = v_q && in_use && (e_q.asid == lk_asid) && (e_q.vpn == lk_vpn);
    assign vld_vec[i] = v_q;
    assign ent_w[i] = e_q;

    always_ff @(posedge clk) begin
      if (rst)       v_q <= 1'b0;
      else if (take) v_q <= 1'b1;
      else if (drop) v_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst)       e_q <= '0;
      else if (take) e_q <= wr_entry;
    end
  end

  // lowest matching line wins
  always_comb begin
    hit     = 1'b0;
    hit_ent = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_ent = ent_w[i];
      end
    end
  end

  // R4: a global untagged drop empties the array
  p_flush_all_r4: assert property (@(posedge clk) disable iff (rst)
    flush_go && flush_cmd.mode == FM_ALL && !flush_cmd.asid_chk && !wr_en
    |=> vld_vec == '0);

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] active_cnt,
  input  logic [LINES-1:0] vld_vec,
  input  logic             adv,
  output logic [IDX_W-1:0] victim_idx
);

  logic [IDX_W-1:0] ptr_q;
  logic [CNT_W-1:0] ptr_ext;
  logic [CNT_W-1:0] ptr_inc;
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_idx;

  assign ptr_ext = {1'b0, ptr_q};
  assign ptr_inc = ptr_ext + CNT_W'(1);

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!vld_vec[i] && (CNT_W'(i) < active_cnt)) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign rr_idx     = (ptr_ext < active_cnt) ? ptr_q : '0;
  assign victim_idx = free_found ? free_idx : rr_idx;

  always_ff @(posedge clk) begin
    if (rst)
      ptr_q <= '0;
    else if (adv)
      ptr_q <= (ptr_inc >= active_cnt) ? '0 : ptr_inc[IDX_W-1:0];
  end

  // R7: the chosen line is always one that is in use
  p_victim_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    (active_cnt != '0) |-> ({1'b0, victim_idx} < active_cnt));

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  cfg_active_lines,
  input  logic        cfg_hum_en,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [6:0]  lk_asid,
  input  logic [19:0] lk_vpn,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic        rsp_retry,
  output logic [19:0] rsp_pfn,
  output logic [2:0]  rsp_perm,
  output logic        miss_valid,
  input  logic        miss_ready,
  output logic [6:0]  miss_asid,
  output logic [19:0] miss_vpn,
  input  logic        fill_valid,
  output logic        fill_ready,
  input  logic [19:0] fill_pfn,
  input  logic [2:0]  fill_perm,
  input  logic        flush_valid,
  input  logic [31:0] flush_word
);

  localparam int IDX_W = $clog2(LINES);
  localparam int CNT_W = IDX_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_e;

  st_e               st_q;
  logic [ASID_W-1:0] pend_asid;
  logic [VPN_W-1:0]  pend_vpn;

  logic [6:0]       cfg_ext;
  logic [CNT_W-1:0] eff_cnt;
  logic             flush_go;
  flush_cmd_t       flush_cmd;
  logic             arr_hit;
  entry_t           arr_ent;
  logic [LINES-1:0] vld_vec;
  logic [IDX_W-1:0] victim_idx;
  logic             lk_fire;
  logic             fill_fire;
  logic             fill_kill;
  logic             install;
  entry_t           new_ent;

  assign cfg_ext = {1'b0, cfg_active_lines};
  assign eff_cnt = (cfg_ext >= 7'(LINES)) ? CNT_W'(LINES) : CNT_W'(cfg_ext);

  tlb_flush_dec u_dec (
    .flush_valid (flush_valid),
    .flush_word  (flush_word),
    .flush_go    (flush_go),
    .flush_cmd   (flush_cmd)
  );

  assign lk_ready   = (st_q == ST_IDLE) ||
                      (cfg_hum_en && !(st_q == ST_WAIT && fill_valid));
  assign lk_fire    = lk_valid && lk_ready;
  assign fill_ready = (st_q == ST_WAIT);
  assign fill_fire  = fill_ready && fill_valid;
  assign fill_kill  = fill_fire && flush_go && flush_covers(flush_cmd, pend_asid, pend_vpn);
  assign install    = fill_fire && !fill_kill && (eff_cnt != '0);

  assign new_ent.asid = pend_asid;
  assign new_ent.vpn  = pend_vpn;
  assign new_ent.pfn  = fill_pfn;
  assign new_ent.perm = fill_perm;

  tlb_tag_array #(.LINES(LINES)) u_arr (
    .clk        (clk),
    .rst        (rst),
    .active_cnt (eff_cnt),
    .lk_asid    (lk_asid),
    .lk_vpn     (lk_vpn),
    .flush_go   (flush_go),
    .flush_cmd  (flush_cmd),
    .wr_en      (install),
    .wr_idx     (victim_idx),
    .wr_entry   (new_ent),
    .hit        (arr_hit),
    .hit_ent    (arr_ent),
    .vld_vec    (vld_vec)
  );

  tlb_victim #(.LINES(LINES)) u_vic (
    .clk        (clk),
    .rst        (rst),
    .active_cnt (eff_cnt),
    .vld_vec    (vld_vec),
    .adv        (install),
    .victim_idx (victim_idx)
  );

  // refill sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      pend_asid <= '0;
      pend_vpn  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (lk_fire && !arr_hit) begin
          st_q      <= ST_REQ;
          pend_asid <= lk_asid;
          pend_vpn  <= lk_vpn;
        end
        ST_REQ:  if (miss_ready) st_q <= ST_WAIT;
        ST_WAIT: if (fill_valid) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign miss_valid = (st_q == ST_REQ);
  assign miss_asid  = pend_asid;
  assign miss_vpn   = pend_vpn;

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_retry <= 1'b0;
      rsp_pfn   <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (fill_fire) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b0;
        rsp_retry <= fill_kill;
        rsp_pfn   <= fill_kill ? '0 : fill_pfn;
        rsp_perm  <= fill_kill ? '0 : fill_perm;
      end else if (lk_fire) begin
        if (arr_hit) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_retry <= 1'b0;
          rsp_pfn   <= arr_ent.pfn;
          rsp_perm  <= arr_ent.perm;
        end else if (st_q != ST_IDLE) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b0;
          rsp_retry <= 1'b1;
          rsp_pfn   <= '0;
          rsp_perm  <= '0;
        end
      end
    end
  end

  // R1: an accepted hit is answered on the next cycle
  p_hit_answer_r1: assert property (@(posedge clk) disable iff (rst)
    lk_fire && arr_hit && !fill_fire |=> rsp_valid && rsp_hit && !rsp_retry);

  // R2: an untaken request holds its value
  p_miss_hold_r2: assert property (@(posedge clk) disable iff (rst)
    miss_valid && !miss_ready |=> miss_valid && $stable(miss_vpn) && $stable(miss_asid));

  // R3: a taken fill is answered on the next cycle
  p_fill_answer_r3: assert property (@(posedge clk) disable iff (rst)
    fill_valid && fill_ready |=> rsp_valid && !rsp_hit);

  // R8: without hit-under-miss, no lookup while a request is open
  p_no_hum_stall_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_hum_en && miss_valid |-> !lk_ready);

  // R9: a fill racing a covering drop is answered with retry
  p_race_retry_r9: assert property (@(posedge clk) disable iff (rst)
    fill_kill |=> rsp_valid && rsp_retry);

endmodule

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  cfg_active_lines;
  logic        cfg_hum_en;
  logic        lk_valid;
  logic        lk_ready;
  logic [6:0]  lk_asid;
  logic [19:0] lk_vpn;
  logic        rsp_valid, rsp_hit, rsp_retry;
  logic [19:0] rsp_pfn;
  logic [2:0]  rsp_perm;
  logic        miss_valid, miss_ready;
  logic [6:0]  miss_asid;
  logic [19:0] miss_vpn;
  logic        fill_valid, fill_ready;
  logic [19:0] fill_pfn;
  logic [2:0]  fill_perm;
  logic        flush_valid;
  logic [31:0] flush_word;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic        got_valid, got_hit, got_retry;
  logic [19:0] got_pfn;
  logic [2:0]  got_perm;

  always #10 clk = ~clk;

  asid_tlb uut (
    .clk(clk), .rst(rst),
    .cfg_active_lines(cfg_active_lines), .cfg_hum_en(cfg_hum_en),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_asid(lk_asid), .lk_vpn(lk_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_retry(rsp_retry),
    .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_asid(miss_asid), .miss_vpn(miss_vpn),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .flush_valid(flush_valid), .flush_word(flush_word)
  );

  function automatic logic [19:0] pfn_of(input logic [19:0] v);
    return v ^ 20'hF0F0F;
  endfunction

  function automatic logic [2:0] perm_of(input logic [19:0] v);
    return v[2:0] ^ 3'b101;
  endfunction

  function automatic logic [31:0] w_group(input logic en, input logic [6:0] a,
                                          input logic [19:0] v);
    return {en, a, 4'h0, v[19:2], 2'b11};
  endfunction

  function automatic logic [31:0] w_sect(input logic en, input logic [6:0] a,
                                         input logic [19:0] v);
    return {en, a, 4'h0, v[19:10], 8'h00, 2'b10};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic grab();
    got_valid = rsp_valid;
    got_hit   = rsp_hit;
    got_retry = rsp_retry;
    got_pfn   = rsp_pfn;
    got_perm  = rsp_perm;
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1; lk_valid = 0; miss_ready = 0; fill_valid = 0; flush_valid = 0;
    lk_asid = '0; lk_vpn = '0; fill_pfn = '0; fill_perm = '0; flush_word = '0;
    cfg_active_lines = 6'd63; cfg_hum_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic lookup(input logic [6:0] a, input logic [19:0] v);
    @(negedge clk);
    lk_valid = 1'b1; lk_asid = a; lk_vpn = v;
    @(negedge clk);
    lk_valid = 1'b0;
    grab();
  endtask

  // called right after a missing lookup; walker answers
  task automatic finish_fill(input logic [19:0] p, input logic [2:0] pm,
                             input logic fl_en, input logic [31:0] fl_w);
    miss_ready = 1'b1;
    @(negedge clk);
    miss_ready = 1'b0;
    fill_valid = 1'b1; fill_pfn = p; fill_perm = pm;
    flush_valid = fl_en; flush_word = fl_w;
    @(negedge clk);
    fill_valid = 1'b0; flush_valid = 1'b0;
    grab();
  endtask

  task automatic refill(input logic [6:0] a, input logic [19:0] v);
    lookup(a, v);
    if (!got_valid) finish_fill(pfn_of(v), perm_of(v), 1'b0, 32'h0);
  endtask

  task automatic probe(input string req, input logic [6:0] a, input logic [19:0] v,
                       input logic exp_hit);
    lookup(a, v);
    check(req, {31'h0, got_valid && got_hit}, {31'h0, exp_hit});
    if (got_valid && got_hit && exp_hit)
      check(req, {9'h0, got_perm, got_pfn}, {9'h0, perm_of(v), pfn_of(v)});
    if (!got_valid) finish_fill(pfn_of(v), perm_of(v), 1'b0, 32'h0);
  endtask

  task automatic flush(input logic [31:0] w);
    @(negedge clk);
    flush_valid = 1'b1; flush_word = w;
    @(negedge clk);
    flush_valid = 1'b0;
  endtask

  task automatic t_reset();
    reset_dut();
    @(negedge clk);
    check("R10 lk_ready", {31'h0, lk_ready}, 32'h1);
    check("R10 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R10 miss_valid", {31'h0, miss_valid}, 32'h0);
    check("R10 fill_ready", {31'h0, fill_ready}, 32'h0);
  endtask

  task automatic t_miss_fill();
    reset_dut();
    lookup(7'd5, 20'h12345);
    check("R2 no response on miss", {31'h0, got_valid}, 32'h0);
    check("R2 miss_valid", {31'h0, miss_valid}, 32'h1);
    check("R2 miss tag", {25'h0, miss_asid}, 32'd5);
    check("R2 miss page", {12'h0, miss_vpn}, 32'h12345);
    @(negedge clk);
    check("R2 request held", {11'h0, miss_valid, miss_vpn}, {11'h0, 1'b1, 20'h12345});
    check("R3 fill_ready", {31'h0, fill_ready}, 32'h0);
    finish_fill(20'hABCDE, 3'b101, 1'b0, 32'h0);
    check("R3 fill response", {8'h0, got_valid, got_hit, got_retry, got_perm, got_pfn},
          {8'h0, 1'b1, 1'b0, 1'b0, 3'b101, 20'hABCDE});
    lookup(7'd5, 20'h12345);
    check("R1 R3 hit after fill", {8'h0, got_valid, got_hit, got_retry, got_perm, got_pfn},
          {8'h0, 1'b1, 1'b1, 1'b0, 3'b101, 20'hABCDE});
    probe("R1 other tag misses", 7'd6, 20'h12345, 1'b0);
  endtask

  task automatic t_flush_modes();
    reset_dut();
    refill(7'd1, 20'h00401);
    refill(7'd1, 20'h00405);
    refill(7'd2, 20'h00402);
    refill(7'd1, 20'h00800);
    flush(w_group(1'b1, 7'd1, 20'h00401));
    probe("R4 R5 group drop", 7'd1, 20'h00401, 1'b0);
    probe("R4 other group kept", 7'd1, 20'h00405, 1'b1);
    probe("R5 other tag kept", 7'd2, 20'h00402, 1'b1);
    probe("R4 other section kept", 7'd1, 20'h00800, 1'b1);
    flush(w_sect(1'b0, 7'd0, 20'h00400));
    probe("R4 section drop", 7'd1, 20'h00405, 1'b0);
    probe("R5 untagged drop", 7'd2, 20'h00402, 1'b0);
    probe("R4 outside section", 7'd1, 20'h00800, 1'b1);
    flush(32'h0000_0401);
    probe("R4 mode 1 drops nothing", 7'd1, 20'h00405, 1'b1);
    flush(32'h8200_0000);
    probe("R5 tagged all drop", 7'd2, 20'h00402, 1'b0);
    probe("R5 tagged all keeps", 7'd1, 20'h00800, 1'b1);
    flush(32'h0000_0000);
    probe("R4 all drop", 7'd1, 20'h00800, 1'b0);
    probe("R4 all drop second", 7'd1, 20'h00405, 1'b0);
  endtask

  task automatic t_active();
    reset_dut();
    cfg_active_lines = 6'd2;
    refill(7'd3, 20'h00100);
    refill(7'd3, 20'h00200);
    refill(7'd3, 20'h00300);
    probe("R6 R7 newer kept", 7'd3, 20'h00200, 1'b1);
    probe("R6 R7 newest kept", 7'd3, 20'h00300, 1'b1);
    probe("R6 R7 oldest evicted", 7'd3, 20'h00100, 1'b0);
    cfg_active_lines = 6'd1;
    probe("R6 line 0 in use", 7'd3, 20'h00300, 1'b1);
    probe("R6 line 1 ignored", 7'd3, 20'h00100, 1'b0);
    probe("R6 single line replaced", 7'd3, 20'h00300, 1'b0);
    cfg_active_lines = 6'd0;
    lookup(7'd3, 20'h00777);
    finish_fill(pfn_of(20'h00777), perm_of(20'h00777), 1'b0, 32'h0);
    check("R6 zero lines still answers", {31'h0, got_valid}, 32'h1);
    probe("R6 zero lines installs nothing", 7'd3, 20'h00777, 1'b0);
    cfg_active_lines = 6'd63;
  endtask

  task automatic t_replace();
    reset_dut();
    cfg_active_lines = 6'd4;
    refill(7'd3, 20'h00010);
    refill(7'd3, 20'h00020);
    refill(7'd3, 20'h00030);
    flush(w_group(1'b0, 7'd0, 20'h00020));
    refill(7'd3, 20'h00040);
    refill(7'd3, 20'h00050);
    refill(7'd3, 20'h00060);
    probe("R7 first line kept", 7'd3, 20'h00010, 1'b1);
    probe("R7 third line kept", 7'd3, 20'h00030, 1'b1);
    probe("R7 free line used", 7'd3, 20'h00050, 1'b1);
    probe("R7 round robin fill", 7'd3, 20'h00060, 1'b1);
    probe("R7 pointer victim", 7'd3, 20'h00040, 1'b0);
    cfg_active_lines = 6'd63;
  endtask

  task automatic t_hum();
    reset_dut();
    cfg_hum_en = 1'b1;
    refill(7'd1, 20'h00111);
    lookup(7'd1, 20'h00222);
    check("R8 miss opens refill", {31'h0, miss_valid}, 32'h1);
    lookup(7'd1, 20'h00111);
    check("R8 hit under miss", {8'h0, got_valid, got_hit, got_retry, got_perm, got_pfn},
          {8'h0, 1'b1, 1'b1, 1'b0, perm_of(20'h00111), pfn_of(20'h00111)});
    lookup(7'd1, 20'h00333);
    check("R8 miss under miss retry", {29'h0, got_valid, got_hit, got_retry},
          {29'h0, 1'b1, 1'b0, 1'b1});
    check("R8 request unchanged", {12'h0, miss_vpn}, 32'h00222);
    finish_fill(pfn_of(20'h00222), perm_of(20'h00222), 1'b0, 32'h0);
    probe("R8 first refill installed", 7'd1, 20'h00222, 1'b1);
    cfg_hum_en = 1'b0;
    lookup(7'd1, 20'h00333);
    check("R8 stall when disabled", {30'h0, miss_valid, lk_ready}, {30'h0, 1'b1, 1'b0});
    finish_fill(pfn_of(20'h00333), perm_of(20'h00333), 1'b0, 32'h0);
  endtask

  task automatic t_race();
    reset_dut();
    lookup(7'd4, 20'h00500);
    finish_fill(pfn_of(20'h00500), perm_of(20'h00500), 1'b1, 32'h8400_0000);
    check("R9 killed fill retry", {30'h0, got_valid, got_retry}, {30'h0, 1'b1, 1'b1});
    probe("R9 killed fill not installed", 7'd4, 20'h00500, 1'b0);
    lookup(7'd5, 20'h00600);
    finish_fill(pfn_of(20'h00600), perm_of(20'h00600), 1'b1, 32'h8400_0000);
    check("R9 uncovered fill", {8'h0, got_valid, got_hit, got_retry, got_perm, got_pfn},
          {8'h0, 1'b1, 1'b0, 1'b0, perm_of(20'h00600), pfn_of(20'h00600)});
    probe("R9 uncovered fill installed", 7'd5, 20'h00600, 1'b1);
  endtask

  initial begin
    rst = 1'b1;
    lk_valid = 0; miss_ready = 0; fill_valid = 0; flush_valid = 0;
    lk_asid = '0; lk_vpn = '0; fill_pfn = '0; fill_perm = '0; flush_word = '0;
    cfg_active_lines = 6'd63; cfg_hum_en = 1'b0;
    t_reset();
    t_miss_fill();
    t_flush_modes();
    t_active();
    t_replace();
    t_hum();
    t_race();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule